// File: doc/BRIEF.md
# Channel Buffer Ring Submission Controller

This block runs the device-to-host side of one streaming channel. It takes words from a user-side FIFO interface and places them into a ring of host buffers through a simple memory-write port. All buffers are the same size. The word address it drives is split into two fields. The upper bits select the buffer and the lower bits give the word offset inside it. This works because both the buffer count and the buffer length are powers of two.

A buffer is handed to the host when its last word is written. It is also handed over, partly filled, when the host has asked for a flush. Each hand-over raises a release notice that names the buffer and the number of bytes it holds. The host later returns the buffer by index. Until then the block will not write into it, and the user side is stalled rather than data being dropped. When enabled, the block also raises a nonempty notice on the first word that lands in an empty buffer. Notices go out on a valid/ready handshake toward a message writer.

Top module: `ring_submit_ctrl`

## Requirements
- R1: A written word goes to word address {buffer index, word offset}. The index is in the upper IDX_W bits and the offset in the lower OFF_W bits. The data is the accepted input word, and offsets rise by one from 0 within a buffer.
- R2: Writing the last word of a buffer raises a release notice (note_kind 0) on the next cycle. The notice names that buffer and gives BUF_WORDS*DATA_W/8 bytes. The following word goes to offset 0 of the next buffer, modulo NBUF.
- R3: A flush_cmd pulse is registered. In the next cycle, if the current buffer holds words, no word is accepted and no release notice is pending, the buffer is released. Its notice carries words*DATA_W/8 bytes, and the next buffer is started.
- R4: A flush that finds the current buffer empty raises no notice. It stays pending, and the next accepted word is followed at once by a release of that buffer, carrying that word's byte count.
- R5: A released buffer is never written again until a return (ret_valid with ret_idx) names it. While the current buffer is held by the host, in_ready and wr_valid are low.
- R6: A return naming a buffer the host does not hold has no effect.
- R7: With nonempty_en high, a word accepted at offset 0 raises a nonempty notice (note_kind 1, note_bytes 0) on the next cycle, naming that buffer. It is presented before any release notice raised in the same cycle.
- R8: While note_valid is high, no input is accepted and wr_valid is low. An unaccepted notice keeps its kind, index and byte count.
- R9: A word is taken from the input only in a cycle where the memory write is valid and ready, so no word is dropped.
- R10: After reset no notice is pending, no buffer is held by the host, no flush is pending and the write position is buffer 0, offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | User word available |
| in_data | input | DATA_W | User word |
| in_ready | output | 1 | Word accepted this cycle when in_valid is high |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | IDX_W+OFF_W | Word address: buffer index, then offset |
| wr_data | output | DATA_W | Word to write |
| wr_ready | input | 1 | Memory write port can take a word |
| flush_cmd | input | 1 | Host request to submit a partly filled buffer |
| ret_valid | input | 1 | Host returns a buffer |
| ret_idx | input | IDX_W | Index of the returned buffer |
| nonempty_en | input | 1 | Enables nonempty notices |
| note_valid | output | 1 | Notice pending |
| note_ready | input | 1 | Message writer takes the notice |
| note_kind | output | 1 | 0 release, 1 nonempty |
| note_idx | output | IDX_W | Buffer named by the notice |
| note_bytes | output | CNT_W | Bytes in the released buffer, 0 for nonempty |

## Verification
Some properties are checked on every cycle. The stall while a notice is pending, the stability of an unaccepted notice and the rule that a take from the input always writes memory are among them. So are the release notice after the last word, the nonempty notice after a first word, and the bound on reported byte counts. A shadow record of host-held buffers, built from accepted notices and returns, guards against writes into a held buffer. Other behaviours can only be shown by the bench's scenarios against its reference model. These are the flush that waits across an empty buffer, the exact partial byte counts, the ignored stray returns and the wrap of the ring.

// File: rtl/ring_submit_pkg.sv
package ring_submit_pkg;
  typedef enum logic {
    NOTE_RELEASE  = 1'b0,
    NOTE_NONEMPTY = 1'b1
  } note_kind_t;
endpackage

// File: rtl/rs_ring_ptr.sv
// Write position: buffer index and word offset inside it.
module rs_ring_ptr #(
  parameter int NBUF      = 4,
  parameter int BUF_WORDS = 4,
  localparam int IDX_W = $clog2(NBUF),
  localparam int OFF_W = $clog2(BUF_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             advance,
  output logic [IDX_W-1:0] idx_o,
  output logic [OFF_W-1:0] off_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [OFF_W-1:0] off_q, off_d;

  always_comb begin
    idx_d = idx_q;
    off_d = off_q;
    if (advance) begin
      idx_d = idx_q + 1'b1;
      off_d = '0;
    end else if (step) begin
      off_d = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      off_q <= '0;
    end else if (advance || step) begin
      idx_q <= idx_d;
      off_q <= off_d;
    end
  end

  assign idx_o = idx_q;
  assign off_o = off_q;
endmodule

// File: rtl/rs_owner.sv
// One held-by-host flag per buffer.
module rs_owner #(
  parameter int NBUF = 4,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             ret_en,
  input  logic [IDX_W-1:0] ret_idx,
  output logic [NBUF-1:0]  held_o
);
  for (genvar b = 0; b < NBUF; b++) begin : g_flag
    logic held_q, held_d, hit_set, hit_ret;
    assign hit_set = set_en && (set_idx == IDX_W'(b));
    assign hit_ret = ret_en && (ret_idx == IDX_W'(b));
    always_comb begin
      held_d = held_q;
      if (hit_set)      held_d = 1'b1;
      else if (hit_ret) held_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                held_q <= 1'b0;
      else if (hit_set || hit_ret) held_q <= held_d;
    end
    assign held_o[b] = held_q;
  end
endmodule

// File: rtl/rs_notice.sv
// Two notice slots: nonempty is shown first, then release.
module rs_notice #(
  parameter int IDX_W = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nz_set,
  input  logic [IDX_W-1:0] nz_idx,
  input  logic             rel_set,
  input  logic [IDX_W-1:0] rel_idx,
  input  logic [CNT_W-1:0] rel_bytes,
  input  logic             note_ready,
  output logic             note_valid,
  output logic             note_kind,
  output logic [IDX_W-1:0] note_idx,
  output logic [CNT_W-1:0] note_bytes,
  output logic             rel_busy
);
  import ring_submit_pkg::*;
  logic             nz_q, nz_d, rel_q, rel_d, take;
  logic [IDX_W-1:0] nzi_q, reli_q;
  logic [CNT_W-1:0] relb_q;

  assign take = note_valid && note_ready;

  always_comb begin
    nz_d  = nz_q;
    rel_d = rel_q;
    if (take && nz_q)       nz_d  = 1'b0;
    else if (take && rel_q) rel_d = 1'b0;
    if (nz_set)  nz_d  = 1'b1;
    if (rel_set) rel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nz_q  <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      nz_q  <= nz_d;
      rel_q <= rel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzi_q  <= '0;
      reli_q <= '0;
      relb_q <= '0;
    end else begin
      if (nz_set) nzi_q <= nz_idx;
      if (rel_set) begin
        reli_q <= rel_idx;
        relb_q <= rel_bytes;
      end
    end
  end

  assign note_valid = nz_q || rel_q;
  assign note_kind  = nz_q ? NOTE_NONEMPTY : NOTE_RELEASE;
  assign note_idx   = nz_q ? nzi_q : reli_q;
  assign note_bytes = nz_q ? '0 : relb_q;
  assign rel_busy   = rel_q;
endmodule

// File: rtl/ring_submit_ctrl.sv
module ring_submit_ctrl #(
  parameter int DATA_W    = 16,
  parameter int NBUF      = 4,
  parameter int BUF_WORDS = 4,
  localparam int IDX_W = $clog2(NBUF),
  localparam int OFF_W = $clog2(BUF_WORDS),
  localparam int CNT_W = $clog2(BUF_WORDS * (DATA_W / 8)) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_data,
  output logic                   in_ready,
  output logic                   wr_valid,
  output logic [IDX_W+OFF_W-1:0] wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  input  logic                   wr_ready,
  input  logic                   flush_cmd,
  input  logic                   ret_valid,
  input  logic [IDX_W-1:0]       ret_idx,
  input  logic                   nonempty_en,
  output logic                   note_valid,
  input  logic                   note_ready,
  output logic                   note_kind,
  output logic [IDX_W-1:0]       note_idx,
  output logic [CNT_W-1:0]       note_bytes
);
  localparam int BYTES = DATA_W / 8;

  logic [IDX_W-1:0] cur_idx;
  logic [OFF_W-1:0] cur_off;
  logic [NBUF-1:0]  held;
  logic             rel_busy, slot_ok, accept, last_word;
  logic             sub_word, sub_part, submit, nz_set;
  logic             fl_q, fl_d;
  logic [OFF_W:0]   sub_words;
  logic [CNT_W-1:0] sub_bytes;

  assign slot_ok  = !note_valid && !held[cur_idx];
  assign in_ready = wr_ready && slot_ok;
  assign wr_valid = in_valid && slot_ok;
  assign wr_addr  = {cur_idx, cur_off};
  assign wr_data  = in_data;
  assign accept   = in_valid && in_ready;

  always_comb begin
    last_word = (cur_off == OFF_W'(BUF_WORDS - 1));
    sub_word  = accept && (last_word || fl_q);
    sub_part  = fl_q && (cur_off != '0) && !accept && !rel_busy;
    submit    = sub_word || sub_part;
    sub_words = {1'b0, cur_off} + {{OFF_W{1'b0}}, sub_word};
    sub_bytes = CNT_W'(sub_words) * CNT_W'(BYTES);
    nz_set    = accept && (cur_off == '0) && nonempty_en;
    fl_d      = (fl_q && !submit) || flush_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= 1'b0;
    else        fl_q <= fl_d;
  end

  rs_ring_ptr #(.NBUF(NBUF), .BUF_WORDS(BUF_WORDS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(accept), .advance(submit),
    .idx_o(cur_idx), .off_o(cur_off)
  );

  rs_owner #(.NBUF(NBUF)) u_own (
    .clk(clk), .rst_n(rst_n), .set_en(submit), .set_idx(cur_idx),
    .ret_en(ret_valid), .ret_idx(ret_idx), .held_o(held)
  );

  rs_notice #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_note (
    .clk(clk), .rst_n(rst_n), .nz_set(nz_set), .nz_idx(cur_idx),
    .rel_set(submit), .rel_idx(cur_idx), .rel_bytes(sub_bytes),
    .note_ready(note_ready), .note_valid(note_valid), .note_kind(note_kind),
    .note_idx(note_idx), .note_bytes(note_bytes), .rel_busy(rel_busy)
  );
endmodule

// File: rtl/ring_submit_chk.sv
module ring_submit_chk #(
  parameter int DATA_W    = 16,
  parameter int NBUF      = 4,
  parameter int BUF_WORDS = 4,
  localparam int IDX_W = $clog2(NBUF),
  localparam int OFF_W = $clog2(BUF_WORDS),
  localparam int CNT_W = $clog2(BUF_WORDS * (DATA_W / 8)) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [IDX_W+OFF_W-1:0] wr_addr,
  input logic                   ret_valid,
  input logic [IDX_W-1:0]       ret_idx,
  input logic                   nonempty_en,
  input logic                   note_valid,
  input logic                   note_ready,
  input logic                   note_kind,
  input logic [IDX_W-1:0]       note_idx,
  input logic [CNT_W-1:0]       note_bytes
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_WORDS * (DATA_W / 8));

  logic [IDX_W-1:0] w_idx;
  logic [OFF_W-1:0] w_off;
  logic             took;
  logic [NBUF-1:0]  shadow;
  assign w_idx = wr_addr[IDX_W+OFF_W-1:OFF_W];
  assign w_off = wr_addr[OFF_W-1:0];
  assign took  = in_valid && in_ready;

  // host-held record built only from accepted release notices and returns
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow <= '0;
    else begin
      if (ret_valid) shadow[ret_idx] <= 1'b0;
      if (note_valid && note_ready && !note_kind) shadow[note_idx] <= 1'b1;
    end
  end

  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> (!in_ready && !wr_valid));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (note_valid && !note_ready) |=> (note_valid && $stable(note_kind)
      && $stable(note_idx) && $stable(note_bytes)));
  a_r9_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    took |-> (wr_valid && wr_ready));
  a_r2_full_release: assert property (@(posedge clk) disable iff (!rst_n)
    (took && w_off == OFF_W'(BUF_WORDS - 1)) |=> (note_valid && !note_kind
      && note_idx == $past(w_idx) && note_bytes == FULL));
  a_r7_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (took && w_off == '0 && nonempty_en) |=> (note_valid && note_kind
      && note_idx == $past(w_idx) && note_bytes == '0));
  a_r3_byte_range: assert property (@(posedge clk) disable iff (!rst_n)
    (note_valid && !note_kind) |-> (note_bytes != '0 && note_bytes <= FULL));
  a_r5_no_reuse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !shadow[w_idx]);
endmodule

bind ring_submit_ctrl ring_submit_chk #(
  .DATA_W(DATA_W), .NBUF(NBUF), .BUF_WORDS(BUF_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .ret_valid(ret_valid), .ret_idx(ret_idx), .nonempty_en(nonempty_en),
  .note_valid(note_valid), .note_ready(note_ready), .note_kind(note_kind),
  .note_idx(note_idx), .note_bytes(note_bytes)
);

// File: tb/ring_submit_ctrl_test.sv
module ring_submit_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NB = 4;
  localparam int BW = 4;
  localparam int BY = DW / 8;

  logic clk, rst_n;
  logic in_valid, in_ready, wr_valid, wr_ready, flush_cmd, ret_valid;
  logic nonempty_en, note_valid, note_ready, note_kind;
  logic [DW-1:0] in_data, wr_data;
  logic [3:0] wr_addr;
  logic [1:0] ret_idx, note_idx;
  logic [3:0] note_bytes;

  ring_submit_ctrl #(.DATA_W(DW), .NBUF(NB), .BUF_WORDS(BW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .flush_cmd(flush_cmd),
    .ret_valid(ret_valid), .ret_idx(ret_idx), .nonempty_en(nonempty_en),
    .note_valid(note_valid), .note_ready(note_ready), .note_kind(note_kind),
    .note_idx(note_idx), .note_bytes(note_bytes)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // reference state
  int m_idx, m_off, m_relidx, m_relbytes, m_nzidx;
  bit m_nz, m_rel, m_fp;
  bit m_own [NB];
  int hq [$];

  initial clk = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic reset_model();
    m_idx = 0; m_off = 0; m_nz = 0; m_rel = 0; m_fp = 0;
    m_relidx = 0; m_relbytes = 0; m_nzidx = 0;
    for (int i = 0; i < NB; i++) m_own[i] = 0;
    hq.delete();
  endtask

  task automatic submit(input int words);
    m_rel = 1; m_relidx = m_idx; m_relbytes = words * BY;
    m_own[m_idx] = 1;
    m_idx = (m_idx + 1) % NB; m_off = 0;
  endtask

  task automatic run(input int n, input int pv, input int pw, input int pn,
                     input int pf, input int pr, input int pb, input bit nz);
    for (int c = 0; c < n; c++) begin
      bit busy, slot, e_ir, acc, take, old_nz, old_rel, used_fp;
      int e_idx, e_bytes;
      @(negedge clk);
      cyc++;
      in_valid    = ($urandom % 100) < pv;
      in_data     = DW'($urandom);
      wr_ready    = ($urandom % 100) < pw;
      note_ready  = ($urandom % 100) < pn;
      flush_cmd   = ($urandom % 100) < pf;
      nonempty_en = nz;
      ret_valid   = 0;
      ret_idx     = 0;
      if (hq.size() > 0 && ($urandom % 100) < pr) begin
        ret_valid = 1; ret_idx = 2'(hq.pop_front());
      end else if (($urandom % 100) < pb) begin
        int r = $urandom % NB;
        if (!m_own[r]) begin ret_valid = 1; ret_idx = 2'(r); end  // stray return, R6
      end
      #1;
      busy  = m_nz || m_rel;
      slot  = !busy && !m_own[m_idx];
      e_ir  = wr_ready && slot;
      chk("R5 R6 R9 in_ready", int'(in_ready), int'(e_ir));
      chk("R8 wr_valid", int'(wr_valid), int'(in_valid && slot));
      chk("R8 note_valid", int'(note_valid), int'(busy));
      if (in_valid && slot) begin
        chk("R1 wr_addr", int'(wr_addr), m_idx * BW + m_off);
        chk("R1 wr_data", int'(wr_data), int'(in_data));
      end
      if (busy) begin
        e_idx   = m_nz ? m_nzidx : m_relidx;
        e_bytes = m_nz ? 0 : m_relbytes;
        chk("R7 note_kind", int'(note_kind), int'(m_nz));
        chk("R2 note_idx", int'(note_idx), e_idx);
        chk("R3 R4 note_bytes", int'(note_bytes), e_bytes);
      end
      // advance reference to the state after the coming edge
      acc = in_valid && e_ir;
      take = busy && note_ready;
      old_nz = m_nz; old_rel = m_rel; used_fp = 0;
      if (take) begin
        if (old_nz) m_nz = 0;
        else begin m_rel = 0; hq.push_back(m_relidx); end
      end
      if (ret_valid && m_own[ret_idx]) m_own[ret_idx] = 0;
      if (acc) begin
        if (nz && m_off == 0) begin m_nz = 1; m_nzidx = m_idx; end
        if (m_off + 1 == BW || m_fp) begin
          used_fp = m_fp; submit(m_off + 1);
        end else m_off++;
      end else if (m_fp && m_off != 0 && !old_rel) begin
        used_fp = 1; submit(m_off);
      end
      m_fp = (m_fp && !used_fp) || flush_cmd;
    end
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; wr_ready = 1; flush_cmd = 0;
    ret_valid = 0; ret_idx = 0; nonempty_en = 0; note_ready = 0;
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10: idle after reset
    chk("R10 note_valid", int'(note_valid), 0);
    chk("R10 in_ready", int'(in_ready), 1);
    chk("R10 wr_addr", int'(wr_addr), 0);
    // R2 R1: steady stream, full buffers, quick returns
    run(400, 90, 95, 90, 0, 60, 0, 1);
    // R5: slow returns force stalls on held buffers
    run(400, 90, 70, 50, 0, 5, 0, 1);
    // R3 R4: sparse input with frequent flushes, some on empty buffers
    run(500, 15, 90, 80, 20, 50, 10, 1);
    // R6 R7: nonempty off, stray returns, back-pressure on notices
    run(400, 60, 60, 30, 10, 30, 40, 0);
    // mixed
    run(400, 50, 80, 60, 5, 40, 20, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule